// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Promotion

This block combines twenty-one interrupt sources into one vectored request for a CPU core. Six of the sources cannot be masked: reset, clock monitor, watchdog, illegal opcode, the XIRQ pin and the software interrupt. Fifteen sources can be masked: the IRQ pin and fourteen peripheral sources. Each peripheral source has a pending flag and a local enable. The block holds the global I mask and the X mask. Software can clear X but has no way to set it again. A 4-bit promote selector lets software lift one maskable source above all other maskable sources. The IRQ pin can work in low-level mode or in falling-edge mode.

Each cycle the block outputs a registered request, the index of the winning source and its 16-bit vector address. The CPU acknowledges the request it takes. The acknowledge saves the mask bits and then sets them. A return strobe restores the saved mask bits. The block does not execute instructions and does not stack registers.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, int_req is 0, mask_i and mask_x are both 1, and promo_code is 4'b0110.
- R2: Source index order, with the highest priority first: 0 reset, 1 clock monitor, 2 watchdog, 3 illegal opcode, 4 XIRQ, 5 SWI, 6 IRQ pin, 7 real-time tick, 8 to 10 capture 1 to 3, 11 to 15 compare 1 to 5, 16 timer overflow, 17 pulse-count overflow, 18 pulse-count edge, 19 SPI done, 20 SCI. Peripheral bit k of periph_flag and periph_en belongs to index 7+k. The lowest pending index wins, unless R5 applies.
- R3: A maskable source is pending only when mask_i is 0. A peripheral source also needs both its flag and its enable at 1. While mask_i is 1, a maskable source is held and raises no request.
- R4: int_vec equals 16'hFFFE minus twice int_idx, so SCI (index 20) gets 16'hFFD6 and reset gets 16'hFFFE.
- R5: The promote codes map to sources as follows:
  - 0 to 4 select index 16 to 20.
  - 5 and 6 select the IRQ pin (index 6).
  - 7 to 15 select the index equal to the code.
  - A pending promoted source beats every other maskable source, but it loses to any pending non-maskable source.
- R6: A write to promo_code takes effect only while mask_i is 1. Otherwise the write is ignored.
- R7: When int_ack is taken, int_req goes to 0 in the next cycle. Taking a maskable source (index 6 or higher) sets mask_i and leaves mask_x unchanged. Taking a non-maskable source sets both mask_i and mask_x.
- R8: XIRQ (index 4) is blocked by mask_x alone. mask_x_clr clears X, and no software input can set X again. The other non-maskable sources are never blocked.
- R9: int_rti restores mask_i and mask_x to the values they had just before the last acknowledge.
- R10: With irq_edge_mode at 0, the IRQ source is active while irq_n is low. With irq_edge_mode at 1, a falling edge on irq_n sets a latch. The latch holds the request after irq_n returns high, and the acknowledge of index 6 clears it.
- R11: The request, index and vector are registered and are re-evaluated every cycle until an acknowledge. A source with higher priority that arrives later replaces the pending winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nmi_req | input | 6 | Non-maskable request lines, bit k is source index k |
| irq_n | input | 1 | External IRQ pin, active low |
| irq_edge_mode | input | 1 | 0 = low-level mode, 1 = falling-edge mode |
| periph_flag | input | 14 | Peripheral pending flags, bit k is index 7+k |
| periph_en | input | 14 | Peripheral local enables, bit k is index 7+k |
| mask_i_set | input | 1 | Software sets the I mask |
| mask_i_clr | input | 1 | Software clears the I mask |
| mask_x_clr | input | 1 | Software clears the X mask (one-way) |
| promo_we | input | 1 | Write strobe for the promote selector |
| promo_wdata | input | 4 | New promote code |
| int_ack | input | 1 | CPU takes the current request |
| int_rti | input | 1 | Return strobe, restores the saved masks |
| int_req | output | 1 | Registered interrupt request |
| int_idx | output | 5 | Index of the winning source |
| int_vec | output | 16 | Vector address of the winner |
| mask_i | output | 1 | Current I mask |
| mask_x | output | 1 | Current X mask |
| promo_code | output | 4 | Current promote selector |

## Verification
Two events can fall in the same cycle here. The first case is a new source with higher priority that arrives while a lower request is waiting for its acknowledge. The bench holds a compare request pending and then raises the software interrupt. It then expects int_idx and int_vec to switch to the new source without any acknowledge. The second case is an acknowledge that lands together with source lines that are still asserted. The bench judges this by checking that int_req drops in the next cycle and that the request comes back only after int_rti clears the mask again. Sweeps over every peripheral bit and every promote code compare the winner with a model computed in the bench.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int SRC_N    = 21;
    localparam int NMI_N    = 6;
    localparam int PERIPH_N = 14;
    localparam int IDX_W    = 5;
    localparam int CODE_W   = 4;
    localparam int VEC_W    = 16;

    typedef logic [IDX_W-1:0]  src_idx_t;
    typedef logic [CODE_W-1:0] promo_t;
    typedef logic [VEC_W-1:0]  vec_t;

    localparam src_idx_t IDX_XIRQ   = 5'd4;
    localparam src_idx_t IDX_IRQ    = 5'd6;
    localparam src_idx_t IDX_PERIPH = 5'd7;
    localparam src_idx_t IDX_TOVF   = 5'd16;
    localparam src_idx_t IDX_NMI_LO = 5'd6;

    localparam promo_t PROMO_RESET = 4'b0110;

    typedef struct packed {
        logic x;
        logic i;
    } mask_t;

    typedef struct packed {
        logic     valid;
        src_idx_t idx;
    } pick_t;

    // Maps a promote code onto the source index it lifts.
    function automatic src_idx_t promo_to_idx(promo_t code);
        src_idx_t r;
        if (code <= 4'd4)
            r = IDX_TOVF + src_idx_t'(code);
        else if (code <= 4'd6)
            r = IDX_IRQ;
        else
            r = src_idx_t'(code);
        return r;
    endfunction

    // Vectors sit two bytes apart, counting down from the top slot.
    function automatic vec_t vec_of(src_idx_t idx, vec_t top);
        return top - {{(VEC_W-IDX_W-1){1'b0}}, idx, 1'b0};
    endfunction

endpackage

// File: rtl/irqc_mask_ctrl.sv
module irqc_mask_ctrl
    import irqc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ack_take,
    input  logic   ack_nmi,
    input  logic   rti,
    input  logic   i_set,
    input  logic   i_clr,
    input  logic   x_clr,
    input  logic   promo_we,
    input  promo_t promo_wdata,
    output mask_t  mask,
    output promo_t promo
);

    mask_t  mask_q;
    mask_t  saved_q;
    promo_t promo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '{x: 1'b1, i: 1'b1};
            saved_q <= '{x: 1'b1, i: 1'b1};
            promo_q <= PROMO_RESET;
        end else begin
            if (ack_take) begin
                saved_q  <= mask_q;
                mask_q.i <= 1'b1;
                if (ack_nmi)
                    mask_q.x <= 1'b1;
            end else if (rti) begin
                mask_q <= saved_q;
            end else begin
                if (i_set)
                    mask_q.i <= 1'b1;
                else if (i_clr)
                    mask_q.i <= 1'b0;
                if (x_clr)
                    mask_q.x <= 1'b0;
            end
            if (promo_we && mask_q.i)
                promo_q <= promo_wdata;
        end
    end

    assign mask  = mask_q;
    assign promo = promo_q;

    // R7
    ack_sets_i_chk: assert property (@(posedge clk) disable iff (rst)
        ack_take |=> mask_q.i);

    // R7
    nmi_ack_sets_x_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_take && ack_nmi) |=> mask_q.x);

    // R8
    x_no_sw_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!ack_take && !rti && !mask_q.x) |=> !mask_q.x);

    // R6
    promo_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (!mask_q.i) |=> $stable(promo_q));

endmodule

// File: rtl/irqc_irq_pin.sv
module irqc_irq_pin (
    input  logic clk,
    input  logic rst,
    input  logic irq_n,
    input  logic edge_mode,
    input  logic clr,
    output logic active
);

    logic prev_q;
    logic latch_q;
    logic fall;

    assign fall = prev_q & ~irq_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b1;
            latch_q <= 1'b0;
        end else begin
            prev_q <= irq_n;
            if (!edge_mode)
                latch_q <= 1'b0;
            else if (fall)
                latch_q <= 1'b1;
            else if (clr)
                latch_q <= 1'b0;
        end
    end

    assign active = edge_mode ? latch_q : ~irq_n;

    // R10
    edge_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && clr && !fall) |=> (!latch_q));

endmodule

// File: rtl/irqc_select.sv
module irqc_select
    import irqc_pkg::*;
(
    input  logic [SRC_N-1:0] pend,
    input  src_idx_t         promo_idx,
    output pick_t            pick
);

    logic     nmi_any;
    logic     msk_any;
    src_idx_t nmi_win;
    src_idx_t msk_win;

    always_comb begin
        nmi_any = 1'b0;
        nmi_win = '0;
        for (int k = NMI_N - 1; k >= 0; k--) begin
            if (pend[k]) begin
                nmi_any = 1'b1;
                nmi_win = src_idx_t'(k);
            end
        end
    end

    always_comb begin
        msk_any = 1'b0;
        msk_win = '0;
        for (int k = SRC_N - 1; k >= NMI_N; k--) begin
            if (pend[k]) begin
                msk_any = 1'b1;
                msk_win = src_idx_t'(k);
            end
        end
    end

    always_comb begin
        pick.valid = nmi_any | msk_any;
        if (nmi_any)
            pick.idx = nmi_win;
        else if (pend[promo_idx])
            pick.idx = promo_idx;
        else
            pick.idx = msk_win;
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irqc_pkg::*;
#(
    parameter logic [15:0] VEC_TOP = 16'hFFFE
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [5:0]  nmi_req,
    input  logic        irq_n,
    input  logic        irq_edge_mode,
    input  logic [13:0] periph_flag,
    input  logic [13:0] periph_en,
    input  logic        mask_i_set,
    input  logic        mask_i_clr,
    input  logic        mask_x_clr,
    input  logic        promo_we,
    input  logic [3:0]  promo_wdata,
    input  logic        int_ack,
    input  logic        int_rti,
    output logic        int_req,
    output logic [4:0]  int_idx,
    output logic [15:0] int_vec,
    output logic        mask_i,
    output logic        mask_x,
    output logic [3:0]  promo_code
);

    mask_t            mask;
    promo_t           promo;
    logic [SRC_N-1:0] pend;
    logic             irq_active;
    logic             ack_take;
    logic             ack_nmi;
    pick_t            pick;
    logic             req_q;
    src_idx_t         idx_q;
    vec_t             vec_q;

    assign ack_take = int_ack & req_q;
    assign ack_nmi  = idx_q < IDX_NMI_LO;

    irqc_mask_ctrl u_mask (
        .clk         (clk),
        .rst         (rst),
        .ack_take    (ack_take),
        .ack_nmi     (ack_nmi),
        .rti         (int_rti),
        .i_set       (mask_i_set),
        .i_clr       (mask_i_clr),
        .x_clr       (mask_x_clr),
        .promo_we    (promo_we),
        .promo_wdata (promo_wdata),
        .mask        (mask),
        .promo       (promo)
    );

    irqc_irq_pin u_pin (
        .clk       (clk),
        .rst       (rst),
        .irq_n     (irq_n),
        .edge_mode (irq_edge_mode),
        .clr       (ack_take && (idx_q == IDX_IRQ)),
        .active    (irq_active)
    );

    // Pending vector: fixed non-maskable lines, XIRQ gated by X,
    // the IRQ pin and the peripherals gated by I.
    generate
        for (genvar g = 0; g < NMI_N; g++) begin : g_nmi
            if (g == int'(IDX_XIRQ)) begin : g_xirq
                assign pend[g] = nmi_req[g] & ~mask.x;
            end else begin : g_fixed
                assign pend[g] = nmi_req[g];
            end
        end
        assign pend[IDX_IRQ] = irq_active & ~mask.i;
        for (genvar p = 0; p < PERIPH_N; p++) begin : g_per
            assign pend[int'(IDX_PERIPH) + p] = periph_flag[p] & periph_en[p] & ~mask.i;
        end
    endgenerate

    irqc_select u_sel (
        .pend      (pend),
        .promo_idx (promo_to_idx(promo)),
        .pick      (pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            idx_q <= '0;
            vec_q <= '0;
        end else if (ack_take) begin
            req_q <= 1'b0;
        end else begin
            req_q <= pick.valid;
            idx_q <= pick.idx;
            vec_q <= vec_of(pick.idx, VEC_TOP);
        end
    end

    assign int_req    = req_q;
    assign int_idx    = idx_q;
    assign int_vec    = vec_q;
    assign mask_i     = mask.i;
    assign mask_x     = mask.x;
    assign promo_code = promo;

    // R3
    masked_needs_i_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (req_q && idx_q >= IDX_NMI_LO) |-> $past(!mask.i));

    // R8
    xirq_needs_x_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (req_q && idx_q == IDX_XIRQ) |-> $past(!mask.x));

    // R7
    ack_drops_req_chk: assert property (@(posedge clk) disable iff (rst)
        ack_take |=> !req_q);

    // R11
    winner_pending_chk: assert property (@(posedge clk) disable iff (rst)
        pick.valid |-> pend[pick.idx]);

endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  nmi_req;
    logic        irq_n;
    logic        irq_edge_mode;
    logic [13:0] periph_flag;
    logic [13:0] periph_en;
    logic        mask_i_set;
    logic        mask_i_clr;
    logic        mask_x_clr;
    logic        promo_we;
    logic [3:0]  promo_wdata;
    logic        int_ack;
    logic        int_rti;
    logic        int_req;
    logic [4:0]  int_idx;
    logic [15:0] int_vec;
    logic        mask_i;
    logic        mask_x;
    logic [3:0]  promo_code;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    irq_prio_ctrl u_irq_prio_ctrl (
        .clk(clk), .rst(rst), .nmi_req(nmi_req), .irq_n(irq_n),
        .irq_edge_mode(irq_edge_mode), .periph_flag(periph_flag),
        .periph_en(periph_en), .mask_i_set(mask_i_set),
        .mask_i_clr(mask_i_clr), .mask_x_clr(mask_x_clr),
        .promo_we(promo_we), .promo_wdata(promo_wdata),
        .int_ack(int_ack), .int_rti(int_rti), .int_req(int_req),
        .int_idx(int_idx), .int_vec(int_vec), .mask_i(mask_i),
        .mask_x(mask_x), .promo_code(promo_code)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected winner, -1 when nothing requests.
    task automatic chk_out(string tag, int e);
        if (e < 0) begin
            chk({tag, " req"}, int'(int_req), 0);
        end else begin
            chk({tag, " req"}, int'(int_req), 1);
            chk({tag, " idx"}, int'(int_idx), e);
            chk({tag, " vec"}, int'(int_vec), 16'hFFFE - 2 * e);
        end
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_i_set();
        mask_i_set = 1'b1; @(negedge clk); mask_i_set = 1'b0;
    endtask

    task automatic pulse_i_clr();
        mask_i_clr = 1'b1; @(negedge clk); mask_i_clr = 1'b0;
    endtask

    task automatic pulse_ack();
        int_ack = 1'b1; @(negedge clk); int_ack = 1'b0;
    endtask

    task automatic pulse_rti();
        int_rti = 1'b1; @(negedge clk); int_rti = 1'b0;
    endtask

    function automatic int promo_exp(int code);
        if (code <= 4) return 16 + code;
        if (code <= 6) return 6;
        return code;
    endfunction

    initial begin
        rst = 1'b1; nmi_req = '0; irq_n = 1'b1; irq_edge_mode = 1'b0;
        periph_flag = '0; periph_en = '0; mask_i_set = 1'b0;
        mask_i_clr = 1'b0; mask_x_clr = 1'b0; promo_we = 1'b0;
        promo_wdata = '0; int_ack = 1'b0; int_rti = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 req", int'(int_req), 0);
        chk("R1 mask_i", int'(mask_i), 1);
        chk("R1 mask_x", int'(mask_x), 1);
        chk("R1 promo", int'(promo_code), 6);

        // R3 held while I=1, then released
        periph_flag = 14'h0001; periph_en = 14'h0001;
        settle();
        chk_out("R3 held", -1);
        pulse_i_clr();
        settle();
        chk_out("R3 released", 7);

        // R2 R4 single-source sweep and ordering sweep
        for (int k = 0; k < 14; k++) begin
            periph_flag = 14'(1 << k); periph_en = 14'(1 << k);
            settle();
            chk_out("R2 R4 single", 7 + k);
            periph_en = '0;
            settle();
            chk_out("R3 enable off", -1);
            periph_flag = '1; periph_en = 14'('1 << k);
            settle();
            chk_out("R2 order", 7 + k);
        end
        periph_flag = '0; periph_en = '0;

        // R5 R6 promotion over all codes
        for (int c = 0; c < 16; c++) begin
            pulse_i_set();
            promo_we = 1'b1; promo_wdata = 4'(c);
            @(negedge clk);
            promo_we = 1'b0;
            chk("R6 write with I=1", int'(promo_code), c);
            pulse_i_clr();
            periph_flag = '1; periph_en = '1; irq_n = 1'b0;
            settle();
            chk_out("R5 promoted", promo_exp(c));
            nmi_req = 6'b100000;
            settle();
            chk_out("R5 below nmi", 5);
            nmi_req = '0; periph_flag = '0; periph_en = '0; irq_n = 1'b1;
        end
        // R6 write ignored while I=0 (I is 0 here)
        promo_we = 1'b1; promo_wdata = 4'd3;
        @(negedge clk);
        promo_we = 1'b0;
        chk("R6 write ignored", int'(promo_code), 15);
        pulse_i_set();

        // R8 R2 non-maskable sources with X=1
        for (int k = 0; k < 6; k++) begin
            nmi_req = 6'(1 << k);
            settle();
            chk_out("R8 nmi with X set", (k == 4) ? -1 : k);
        end
        mask_x_clr = 1'b1; @(negedge clk); mask_x_clr = 1'b0;
        nmi_req = 6'b010000;
        settle();
        chk_out("R8 xirq after clear", 4);
        nmi_req = 6'b111111;
        settle();
        chk_out("R2 nmi order", 0);
        nmi_req = '0;
        pulse_i_set();
        pulse_i_clr();
        chk("R8 x stays clear", int'(mask_x), 0);

        // R7 R9 R11 acknowledge and return
        periph_flag = 14'h0010; periph_en = 14'h0010;
        settle();
        chk_out("R7 pre-ack", 11);
        pulse_ack();
        chk("R7 maskable ack I", int'(mask_i), 1);
        chk("R7 maskable ack X", int'(mask_x), 0);
        chk("R7 req drops", int'(int_req), 0);
        settle();
        chk_out("R7 held after ack", -1);
        pulse_rti();
        chk("R9 restore I", int'(mask_i), 0);
        chk("R9 restore X", int'(mask_x), 0);
        settle();
        chk_out("R9 request back", 11);
        nmi_req = 6'b100000;
        settle();
        chk_out("R11 late higher replaces", 5);
        pulse_ack();
        chk("R7 nmi ack I", int'(mask_i), 1);
        chk("R7 nmi ack X", int'(mask_x), 1);
        nmi_req = '0; periph_flag = '0; periph_en = '0;
        pulse_rti();
        chk("R9 nmi restore I", int'(mask_i), 0);
        chk("R9 nmi restore X", int'(mask_x), 0);

        // R10 IRQ pin modes
        irq_n = 1'b0;
        settle();
        chk_out("R10 level low", 6);
        irq_n = 1'b1;
        settle();
        chk_out("R10 level high", -1);
        irq_edge_mode = 1'b1;
        settle();
        chk_out("R10 edge idle", -1);
        irq_n = 1'b0; @(negedge clk); irq_n = 1'b1;
        settle();
        chk_out("R10 edge latched", 6);
        pulse_ack();
        pulse_rti();
        settle();
        chk_out("R10 latch cleared", -1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule